// File: doc/BRIEF.md
# Scatter-Gather Region Table Walker

This block moves a requested number of bytes between a device-side byte stream and a set of memory regions listed in a descriptor table. A start pulse hands it the table's base address, a byte count and a direction. It reads 8-byte descriptors one at a time over a 32-bit descriptor read port. Each descriptor gives a region start address and a control word carrying a length and an end-of-table mark. It then moves bytes one at a time between the stream and the current region through a byte-wide memory port.

The walker keeps the remaining length of the current region, the remaining request and an end-of-table flag. It fetches a new descriptor only when the current region is used up. It stops reading the table when the end mark has been seen or when 4096 bytes of table have been read. When the request is satisfied it pulses `done`. When the table runs out first it pulses `done` together with `exhausted`, and a status register outside the block uses that pulse to clear its active bit.

Top module: `prd_walker`

## Requirements
- R1: After reset, busy, done, exhausted, desc_req, mem_req, s_ready and m_valid are all low.
- R2: Descriptors are read as two 32-bit little-endian words: the region address at the descriptor pointer, then the control word at pointer+4. The first descriptor is at table_base with bits 1:0 treated as zero.
- R3: The region length is control bits 15:1 followed by a zero bit, so control bit 0 has no effect. A computed length of zero means 65536 bytes.
- R4: Control bit 31 set marks the final descriptor, and no descriptor is read after it.
- R5: The descriptor pointer advances by 8 per descriptor. A new descriptor is read only once the current region's remaining length is zero.
- R6: Once the pointer is 4096 or more bytes past the table base, no further descriptor is read, even without an end mark.
- R7: Bytes go to consecutive region addresses starting at the region address. Each region takes the smaller of its length and the bytes still requested. For to_mem=1, stream bytes are written to memory in stream order.
- R8: For to_mem=0, memory bytes read from the region addresses are presented on the output stream in order.
- R9: A request of zero bytes completes with done and no descriptor read or memory access.
- R10: done is a one-cycle pulse per run. exhausted is high only with done, and only when the table ended with requested bytes left.
- R11: A start pulse while busy is ignored and does not change the run in progress.
- R12: Each start clears the region length, region address and end flag, so a new run never uses a region left over from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when idle |
| table_base | input | AW | Descriptor table base address |
| req_bytes | input | CW | Number of bytes to move |
| to_mem | input | 1 | 1: stream to memory, 0: memory to stream |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| exhausted | output | 1 | With done: table ended before the request |
| desc_req | output | 1 | Descriptor word read request |
| desc_addr | output | AW | Descriptor word address |
| desc_rdata | input | 32 | Descriptor word data, valid with desc_ack |
| desc_ack | input | 1 | Descriptor read completes this cycle |
| s_valid | input | 1 | Input stream byte valid |
| s_data | input | 8 | Input stream byte |
| s_ready | output | 1 | Input stream byte accepted |
| m_valid | output | 1 | Output stream byte valid |
| m_data | output | 8 | Output stream byte |
| m_ready | input | 1 | Output stream byte taken |
| mem_req | output | 1 | Region byte access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Region byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Region access completes this cycle |

## Verification
Every memory access and descriptor read completes on the rising edge where its ack is high. The bench raises acks and stream handshakes at random in the half cycle before that edge and logs each transfer in that same half cycle, so the logs line up with what the design consumed. done rises one cycle after the walker's decision state sees the request empty or the table ended. Because the ack latency is random, the bench waits for the done pulse rather than a fixed cycle count. It then compares the logged descriptor addresses, region addresses, data bytes and the exhausted flag with a model walk of the same table, and watches four more cycles to confirm that done does not pulse again.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_CHECK, W_FETCH_A, W_FETCH_C, W_XFER
  } walk_state_t;

  typedef enum logic [2:0] {
    X_IDLE, X_TAKE, X_MEMW, X_MEMR, X_PUSH
  } move_state_t;

  localparam int DESC_BYTES = 8;
  localparam int LEN_W      = 17;
endpackage

// File: rtl/prd_len_decode.sv
module prd_len_decode
  import prd_pkg::*;
(
  input  logic [31:0]      ctrl,
  output logic [LEN_W-1:0] len,
  output logic             last
);
  logic [14:0] half;

  always_comb begin
    half = ctrl[15:1];
    if (half == '0) len = LEN_W'(1) << 16;
    else            len = LEN_W'({half, 1'b0});
    last = ctrl[31];
  end
endmodule

// File: rtl/prd_table_limit.sv
module prd_table_limit #(
  parameter int AW    = 32,
  parameter int LIMIT = 4096
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] ptr,
  output logic          at_limit
);
  localparam logic [AW-1:0] LIM = AW'(LIMIT);
  logic [AW-1:0] used;

  always_comb begin
    used     = ptr - base;
    at_limit = (used >= LIM);
  end
endmodule

// File: rtl/prd_byte_mover.sv
module prd_byte_mover
  import prd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          to_mem,
  input  logic [AW-1:0] addr,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  output logic          s_ready,
  output logic          m_valid,
  output logic [7:0]    m_data,
  input  logic          m_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack,
  output logic          byte_done
);
  move_state_t st;
  logic [7:0]  data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= X_IDLE;
      data_q <= '0;
    end else begin
      case (st)
        X_IDLE:  if (en) st <= to_mem ? X_TAKE : X_MEMR;
        X_TAKE:  if (s_valid) begin
                   data_q <= s_data;
                   st     <= X_MEMW;
                 end
        X_MEMW:  if (mem_ack) st <= X_IDLE;
        X_MEMR:  if (mem_ack) begin
                   data_q <= mem_rdata;
                   st     <= X_PUSH;
                 end
        X_PUSH:  if (m_ready) st <= X_IDLE;
        default: st <= X_IDLE;
      endcase
    end
  end

  always_comb begin
    s_ready   = (st == X_TAKE);
    m_valid   = (st == X_PUSH);
    m_data    = data_q;
    mem_req   = (st == X_MEMW) || (st == X_MEMR);
    mem_we    = (st == X_MEMW);
    mem_addr  = addr;
    mem_wdata = data_q;
    byte_done = ((st == X_MEMW) && mem_ack) || ((st == X_PUSH) && m_ready);
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R8
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CW          = 20,
  parameter int TABLE_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] table_base,
  input  logic [CW-1:0] req_bytes,
  input  logic          to_mem,
  output logic          busy,
  output logic          done,
  output logic          exhausted,
  output logic          desc_req,
  output logic [AW-1:0] desc_addr,
  input  logic [31:0]   desc_rdata,
  input  logic          desc_ack,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  output logic          s_ready,
  output logic          m_valid,
  output logic [7:0]    m_data,
  input  logic          m_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);
  localparam logic [AW-1:0] HALF = AW'(DESC_BYTES / 2);

  walk_state_t      st;
  logic [AW-1:0]    base_q, ptr_q, cur_addr;
  logic [LEN_W-1:0] cur_len;
  logic [CW-1:0]    remain_q;
  logic             last_q, dir_q, done_q, exh_q;
  logic [LEN_W-1:0] dec_len;
  logic             dec_last, at_limit, byte_done;

  prd_len_decode u_dec (
    .ctrl (desc_rdata),
    .len  (dec_len),
    .last (dec_last)
  );

  prd_table_limit #(.AW(AW), .LIMIT(TABLE_LIMIT)) u_lim (
    .base     (base_q),
    .ptr      (ptr_q),
    .at_limit (at_limit)
  );

  prd_byte_mover #(.AW(AW)) u_mov (
    .clk       (clk),
    .rst       (rst),
    .en        (st == W_XFER),
    .to_mem    (dir_q),
    .addr      (cur_addr),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_ready   (s_ready),
    .m_valid   (m_valid),
    .m_data    (m_data),
    .m_ready   (m_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .byte_done (byte_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= W_IDLE;
      base_q   <= '0;
      ptr_q    <= '0;
      cur_addr <= '0;
      cur_len  <= '0;
      remain_q <= '0;
      last_q   <= 1'b0;
      dir_q    <= 1'b0;
      done_q   <= 1'b0;
      exh_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      exh_q  <= 1'b0;
      case (st)
        W_IDLE: if (start) begin
          base_q   <= {table_base[AW-1:2], 2'b00};
          ptr_q    <= {table_base[AW-1:2], 2'b00};
          cur_addr <= '0;
          cur_len  <= '0;
          last_q   <= 1'b0;
          remain_q <= req_bytes;
          dir_q    <= to_mem;
          st       <= W_CHECK;
        end
        W_CHECK: begin
          if (remain_q == '0) begin
            done_q <= 1'b1;
            st     <= W_IDLE;
          end else if (cur_len != '0) begin
            st <= W_XFER;
          end else if (last_q || at_limit) begin
            done_q <= 1'b1;
            exh_q  <= 1'b1;
            st     <= W_IDLE;
          end else begin
            st <= W_FETCH_A;
          end
        end
        W_FETCH_A: if (desc_ack) begin
          cur_addr <= desc_rdata[AW-1:0];
          st       <= W_FETCH_C;
        end
        W_FETCH_C: if (desc_ack) begin
          cur_len <= dec_len;
          last_q  <= dec_last;
          ptr_q   <= ptr_q + STEP;
          st      <= W_CHECK;
        end
        W_XFER: if (byte_done) begin
          cur_addr <= cur_addr + 1'b1;
          cur_len  <= cur_len - 1'b1;
          remain_q <= remain_q - 1'b1;
          st       <= W_CHECK;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st != W_IDLE);
    done      = done_q;
    exhausted = exh_q;
    desc_req  = (st == W_FETCH_A) || (st == W_FETCH_C);
    desc_addr = (st == W_FETCH_C) ? (ptr_q + HALF) : ptr_q;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_EXH_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    exhausted |-> done); // R10
  AST_FETCH_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    desc_req |-> (cur_len == '0)); // R5
  AST_NO_FETCH_PAST_END: assert property (@(posedge clk) disable iff (rst)
    $rose(desc_req) |-> (!last_q && !at_limit)); // R6
  AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> (remain_q == $past(remain_q) - 1'b1)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(base_q) && $stable(dir_q))); // R11
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!desc_req && !mem_req)); // R1
endmodule

// File: tb/prd_walker_tb.sv
module prd_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] table_base = '0;
  logic [19:0] req_bytes = '0;
  logic        to_mem = 1'b0;
  logic        busy, done, exhausted, desc_req, s_ready, m_valid, mem_req, mem_we;
  logic [31:0] desc_addr, mem_addr;
  logic [7:0]  m_data, mem_wdata;
  logic [31:0] desc_rdata = '0;
  logic        desc_ack = 1'b0;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        m_ready = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #5 clk = ~clk;

  prd_walker u_dut (
    .clk(clk), .rst(rst), .start(start), .table_base(table_base),
    .req_bytes(req_bytes), .to_mem(to_mem), .busy(busy), .done(done),
    .exhausted(exhausted), .desc_req(desc_req), .desc_addr(desc_addr),
    .desc_rdata(desc_rdata), .desc_ack(desc_ack), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .m_valid(m_valid), .m_data(m_data),
    .m_ready(m_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int errors = 0;
  int checks = 0;
  bit [7:0] mem [int unsigned];
  int unsigned fetch_log[$], acc_log[$], exp_fetch[$], exp_acc[$];
  bit [7:0] data_log[$];
  bit exp_exh;
  int done_cnt = 0;
  bit exh_seen = 0;
  int unsigned src_idx = 0;
  bit s_hs = 0;
  int unsigned cyc = 0;

  function automatic bit [7:0] pat(int unsigned a);
    return a[7:0] ^ a[15:8] ^ 8'h5a;
  endfunction
  function automatic bit [7:0] src_byte(int unsigned k);
    return 8'(k * 13 + 7);
  endfunction
  function automatic bit [7:0] rdb(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic bit [31:0] rd32(int unsigned a);
    return {rdb(a + 3), rdb(a + 2), rdb(a + 1), rdb(a)};
  endfunction
  task automatic put32(int unsigned a, bit [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
  endtask
  task automatic put_desc(int unsigned p, int unsigned ra, bit [31:0] ctl);
    put32(p, ra);
    put32(p + 4, ctl);
  endtask

  // Model walk of the table, written from the requirements.
  task automatic model(int unsigned base, int unsigned req);
    int unsigned ptr, len, addr, rem;
    bit last;
    bit [31:0] c;
    exp_fetch.delete(); exp_acc.delete();
    ptr = base & ~32'd3; len = 0; addr = 0; last = 0; rem = req; exp_exh = 0;
    while (rem > 0) begin
      if (len == 0) begin
        if (last || (ptr - (base & ~32'd3)) >= 4096) begin exp_exh = 1; break; end
        exp_fetch.push_back(ptr); exp_fetch.push_back(ptr + 4);
        addr = rd32(ptr); c = rd32(ptr + 4);
        len = {16'd0, c[15:1], 1'b0};
        if (len == 0) len = 65536;
        last = c[31];
        ptr += 8;
      end
      exp_acc.push_back(addr);
      addr++; len--; rem--;
    end
  endtask

  task automatic chk(bit ok, string rq, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  // Responders: decide acks in the half cycle before the consuming edge.
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      desc_ack = 0; mem_ack = 0; m_ready = 0;
    end else begin
      desc_ack = 0;
      if (desc_req && ($urandom % 4 != 0)) begin
        desc_ack = 1; desc_rdata = rd32(desc_addr); fetch_log.push_back(desc_addr);
      end
      mem_ack = 0;
      if (mem_req && ($urandom % 3 != 0)) begin
        mem_ack = 1; acc_log.push_back(mem_addr);
        if (mem_we) begin mem[mem_addr] = mem_wdata; data_log.push_back(mem_wdata); end
        else mem_rdata = pat(mem_addr);
      end
      m_ready = ($urandom % 3 != 0);
      if (m_valid && m_ready) data_log.push_back(m_data);
      if (done) begin done_cnt++; exh_seen = exhausted; end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      s_valid = 0; s_hs = 0; src_idx = 0;
    end else begin
      if (s_hs) src_idx++;
      s_valid = ($urandom % 3 != 0);
      s_data = src_byte(src_idx);
      #1 s_hs = s_valid && s_ready;
    end
  end

  task automatic run(int unsigned base, int unsigned req, bit wr, string rq, bit poke);
    int d0, wait_c;
    int unsigned s0;
    model(base, req);
    fetch_log.delete(); acc_log.delete(); data_log.delete();
    d0 = done_cnt;
    @(negedge clk);
    s0 = src_idx;
    start = 1; table_base = base; req_bytes = 20'(req); to_mem = wr;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; table_base = base + 32'h40; req_bytes = 20'(req + 5); to_mem = !wr;
      @(negedge clk);
      start = 0;
    end
    wait_c = 0;
    while (done_cnt == d0 && wait_c < 40000) begin @(negedge clk); wait_c++; end
    repeat (4) @(negedge clk);
    chk(done_cnt - d0 == 1, "R10", {rq, " done pulses"}, done_cnt - d0, 1);
    chk(exh_seen == exp_exh, "R10", {rq, " exhausted"}, exh_seen, exp_exh);
    chk(fetch_log.size() == exp_fetch.size(), "R5", {rq, " fetch count"}, fetch_log.size(), exp_fetch.size());
    foreach (exp_fetch[i]) if (i < fetch_log.size() && fetch_log[i] != exp_fetch[i]) begin
      chk(0, "R2", {rq, " fetch address"}, fetch_log[i], exp_fetch[i]); break;
    end
    chk(acc_log.size() == exp_acc.size(), "R7", {rq, " access count"}, acc_log.size(), exp_acc.size());
    foreach (exp_acc[i]) if (i < acc_log.size() && acc_log[i] != exp_acc[i]) begin
      chk(0, "R7", {rq, " region address"}, acc_log[i], exp_acc[i]); break;
    end
    chk(data_log.size() == exp_acc.size(), wr ? "R7" : "R8", {rq, " byte count"}, data_log.size(), exp_acc.size());
    foreach (data_log[i]) begin
      bit [7:0] e;
      e = wr ? src_byte(s0 + i) : pat(i < acc_log.size() ? acc_log[i] : 0);
      if (data_log[i] != e) begin
        chk(0, wr ? "R7" : "R8", {rq, " data"}, data_log[i], e); break;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk({busy, done, exhausted, desc_req, mem_req, s_ready, m_valid} == 0, "R1", "quiet after reset",
        {busy, done, exhausted, desc_req, mem_req, s_ready, m_valid}, 0);

    // R2/R4/R7: two regions, end mark on second, exact fit
    put_desc(32'h1000, 32'h0010_0000, 32'h0000_0006);
    put_desc(32'h1008, 32'h0010_0100, 32'h8000_000a);
    put_desc(32'h1010, 32'h0010_0200, 32'h8000_0010);
    run(32'h1000, 16, 1, "R2 R4 two-region write", 0);
    // R3: odd length field loses bit 0; misaligned base (R2)
    put_desc(32'h1100, 32'h0011_0000, 32'h0000_0005);
    put_desc(32'h1108, 32'h0011_0100, 32'h8000_0008);
    run(32'h1103, 10, 0, "R3 odd length read", 0);
    // R3: zero length field means 65536
    put_desc(32'h1200, 32'h0012_0000, 32'h8000_0001);
    run(32'h1200, 120, 1, "R3 zero field", 0);
    // R10/R4: table ends early
    put_desc(32'h1300, 32'h0013_0000, 32'h0000_0004);
    put_desc(32'h1308, 32'h0013_0100, 32'h8000_0004);
    put_desc(32'h1310, 32'h0013_0200, 32'h8000_0040);
    run(32'h1300, 30, 0, "R10 exhausted", 0);
    // R9: zero request
    run(32'h1300, 0, 1, "R9 zero request", 0);
    // R12: prior run left region state; restart from a fresh table
    run(32'h1000, 4, 0, "R12 fresh start", 0);
    // R11: start while busy ignored
    run(32'h1100, 12, 1, "R11 start while busy", 1);
    // R6: 512 entries without end mark, entry beyond limit never read
    for (int i = 0; i < 513; i++)
      put_desc(32'h4000 + 8*i, 32'h0020_0000 + 16*i, (i == 512) ? 32'h8000_0100 : 32'h0000_0002);
    run(32'h4000, 2000, 1, "R6 table limit", 0);
    // Random tables
    for (int r = 0; r < 12; r++) begin
      int unsigned b, n, tot, rq;
      b = 32'h0003_0000 + r * 32'h100;
      n = 1 + $urandom % 5;
      tot = 0;
      for (int i = 0; i < n; i++) begin
        bit [31:0] ctl;
        ctl = {16'd0, 16'(2 + $urandom % 40)};
        if (i == n - 1) ctl[31] = 1'b1;
        put_desc(b + 8*i, 32'h0040_0000 + r * 32'h1_0000 + i * 32'h1000, ctl);
        tot += {ctl[15:1], 1'b0};
      end
      rq = 1 + $urandom % (tot + 8);
      run(b, rq, r[0], "R7 R8 random", 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule